// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block takes eight interrupt request lines, records them in a request register and filters them through a per-input mask. It resolves a fixed priority among the requests that remain, with input 0 highest, and compares the winner against the levels already in service. It raises one interrupt line toward the processor. When the processor answers with a single-cycle acknowledge, the block drives an 8-bit vector on that same cycle and moves the winning request into the in-service register.

Software reaches the block over a small register bus. The bus has a one-bit address: 0 selects the command port and 1 selects the data port. It also has a write strobe, a read strobe and 8-bit write and read data. A command write of 0x11 opens the initialization sequence, and the next three data writes supply the vector base, the cascade word and the mode word. Once the sequence is complete, data-port writes and reads reach the mask. Command writes can end the service of one level or choose which register a command-port read returns.

The block can sit at the head of a cascade. When it is configured as the head, it stays off the vector bus for any input that the cascade word marks as carrying a downstream controller.

Top module: `vic8_ctrl`

## Requirements
- R1: After reset, `int_out` is low, a data-port read returns 0xFF, and a command-port read returns the request register, which is 0x00.
- R2: A command write of 0x11 starts initialization. The next three data writes are stored in turn as the vector base, the cascade word and the mode word. After that, data writes load the mask and data reads return it.
- R3: A command write with bit 4 set (0x11) clears the request and in-service registers, sets the mask to 0xFF and returns command-port reads to the request register.
- R4: An input whose `trig_level` bit is 0 sets its request bit on a rising edge only. A line held high after its acknowledge does not request again. An input whose `trig_level` bit is 1 requests for as long as the line is high, including after its end of service.
- R5: A masked input still records its request in the request register, but it never raises `int_out` and never wins an acknowledge.
- R6: `int_out` is high when the lowest-numbered unmasked pending request has a lower number than every set in-service bit. An empty in-service register blocks nothing.
- R7: On an acknowledge with a valid winner n, `vector` equals the base plus n on that cycle. The edge-latched request bit n clears, and in-service bit n sets unless automatic end of service is on.
- R8: When bit 1 of the mode word is set (mode word 0x03), an acknowledge leaves the in-service register unchanged.
- R9: A command write of 0x60 plus L, with L from 0 to 7, clears in-service bit L and no other bit.
- R10: A command write of 0x0A makes command-port reads return the request register. A write of 0x0B makes them return the in-service register. The choice holds until the next such write.
- R11: An acknowledge with no eligible request returns the base plus 7 and changes no in-service bit. This also happens when input 7 is masked and when a level request has dropped before the acknowledge.
- R12: With `role_master` high, `vec_drive` is low during an acknowledge whose winner has its bit set in the cascade word (0x04 marks input 2). With `role_master` low, the cascade word has no effect and `vec_drive` follows `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid during the strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is in progress |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-input trigger select: 1 for level, 0 for rising edge |
| role_master | input | 1 | High when this controller heads a cascade |
| ack | input | 1 | Single-cycle interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector for the acknowledged input, valid while `ack` is high |
| vec_drive | output | 1 | High when this controller drives `vector` during the acknowledge |

## Verification
The bench targets nesting. A lower-priority request that arrives while a higher level is in service must stay silent, and a higher-priority one must break through. If the design compared against the wrong end of the in-service set, it would either lose the breakthrough or interrupt inside a running handler. The bench ends service one level at a time with specific end-of-service commands and reads the in-service register back. A design that cleared too many bits would then release a blocked request early.

It holds edge inputs high after their acknowledge, which exposes a design that relatches them and loops forever. It then takes a level request through service and checks that the request returns. The bench also acknowledges with nothing eligible: with all inputs masked, and after a level request has vanished. A design that set an in-service bit in either case, or returned a vector other than base plus 7, would hang later interrupts.

Re-initialization is checked while state is pending and with the in-service register selected for reads. A design that kept the old mask, the old requests or the read selection would fail there. The cascade word is checked under both roles.

// File: rtl/vic8_pkg.sv
// Package: shared types and command decoders for the eight-input vectored
// interrupt controller. Assumes an 8-bit register bus.
package vic8_pkg;

    localparam int DW = 8;

    // Progress through the initialization word sequence.
    typedef enum logic [1:0] {
        CFG_RUN       = 2'd0,
        CFG_WANT_BASE = 2'd1,
        CFG_WANT_CASC = 2'd2,
        CFG_WANT_MODE = 2'd3
    } cfg_state_t;

    // A command byte with bit 4 set opens initialization.
    function automatic logic is_init_cmd(input logic [DW-1:0] d);
        return d[4];
    endfunction

    // Specific end of service: 0110_0LLL.
    function automatic logic is_seoi_cmd(input logic [DW-1:0] d);
        return d[7:3] == 5'b01100;
    endfunction

    // Status read selection: 0xx0_1x1s, where s picks the in-service register.
    function automatic logic is_rdsel_cmd(input logic [DW-1:0] d);
        return (d[7] == 1'b0) && (d[4:3] == 2'b01) && d[1];
    endfunction

endpackage

// File: rtl/vic8_regs.sv
// Module: vic8_regs
// Decodes the register bus. It holds the initialization sequencer, the
// vector base, the cascade word, the mode bits, the mask and the status
// read selection, and it drives the read data mux. It assumes a single
// write or read per cycle and N_IN <= 8.
module vic8_regs
    import vic8_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_IN-1:0] irr,
    input  logic [N_IN-1:0] isr,
    output logic            init_clr,
    output logic            eoi_valid,
    output logic [2:0]      eoi_lvl,
    output logic [DW-1:0]   vec_base,
    output logic [DW-1:0]   casc_map,
    output logic            aeoi,
    output logic            ltim,
    output logic [N_IN-1:0] imr
);

    cfg_state_t      cfg_q;
    logic [N_IN-1:0] imr_q;
    logic [DW-1:0]   base_q;
    logic [DW-1:0]   casc_q;
    logic            aeoi_q;
    logic            ltim_q;
    logic            rsel_isr_q;
    logic            cmd_wr;
    logic            dat_wr;

    assign cmd_wr    = bus_wr && !bus_addr;
    assign dat_wr    = bus_wr && bus_addr;
    assign init_clr  = cmd_wr && is_init_cmd(bus_wdata);
    assign eoi_valid = cmd_wr && is_seoi_cmd(bus_wdata);
    assign eoi_lvl   = bus_wdata[2:0];

    // Initialization sequencer and capture of the three configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RUN;
            base_q <= '0;
            casc_q <= '0;
            aeoi_q <= 1'b0;
            ltim_q <= 1'b0;
        end else if (init_clr) begin
            cfg_q  <= CFG_WANT_BASE;
            ltim_q <= bus_wdata[3];
        end else if (dat_wr) begin
            unique case (cfg_q)
                CFG_WANT_BASE: begin
                    base_q <= bus_wdata;
                    cfg_q  <= CFG_WANT_CASC;
                end
                CFG_WANT_CASC: begin
                    casc_q <= bus_wdata;
                    cfg_q  <= CFG_WANT_MODE;
                end
                CFG_WANT_MODE: begin
                    aeoi_q <= bus_wdata[1];
                    cfg_q  <= CFG_RUN;
                end
                default: cfg_q <= CFG_RUN;
            endcase
        end
    end

    // Mask register: all ones at reset and at the start of init, otherwise
    // loaded by data writes once the sequence has finished.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            imr_q <= '1;
        end else if (dat_wr && cfg_q == CFG_RUN) begin
            imr_q <= bus_wdata[N_IN-1:0];
        end
    end

    // Status read selection, which persists until the next selection command.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            rsel_isr_q <= 1'b0;
        end else if (cmd_wr && is_rdsel_cmd(bus_wdata)) begin
            rsel_isr_q <= bus_wdata[0];
        end
    end

    // Read data mux: the data port gives the mask, the command port gives
    // the selected status register.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr) begin
                bus_rdata = DW'(imr_q);
            end else if (rsel_isr_q) begin
                bus_rdata = DW'(isr);
            end else begin
                bus_rdata = DW'(irr);
            end
        end
    end

    assign vec_base = base_q;
    assign casc_map = casc_q;
    assign aeoi     = aeoi_q;
    assign ltim     = ltim_q;
    assign imr      = imr_q;

    // R3
    init_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (imr_q == '1 && cfg_q == CFG_WANT_BASE && !rsel_isr_q));

    // R2
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cfg_q == CFG_WANT_MODE) |=> (cfg_q == CFG_RUN));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !init_clr) |=> $stable(imr_q));

endmodule

// File: rtl/vic8_req.sv
// Module: vic8_req
// Request register. Each input is captured either on a rising edge, where
// the bit is held until an acknowledge clears it, or as a level, where the
// bit follows the line. It assumes the request lines are already
// synchronous to clk.
module vic8_req #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] trig_level,
    input  logic            ltim,
    input  logic            init_clr,
    input  logic [N_IN-1:0] ack_clr,
    output logic [N_IN-1:0] irr
);

    logic [N_IN-1:0] irq_q;
    logic [N_IN-1:0] irr_q;
    logic [N_IN-1:0] lvl_sel;

    assign lvl_sel = trig_level | {N_IN{ltim}};

    // Previous line state, used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    // One capture cell per input, edge or level as its select bit says.
    for (genvar g = 0; g < N_IN; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n || init_clr) begin
                irr_q[g] <= 1'b0;
            end else if (lvl_sel[g]) begin
                irr_q[g] <= irq_in[g];
            end else begin
                irr_q[g] <= (irr_q[g] && !ack_clr[g]) || (irq_in[g] && !irq_q[g]);
            end
        end
    end

    assign irr = irr_q;

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_clr |=> ((($past(irr_q) & ~$past(ack_clr) & ~$past(lvl_sel)) & ~irr_q) == '0));

    // R4
    edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_clr |=> (((~$past(irr_q)) & ~$past(lvl_sel) & ~($past(irq_in) & ~$past(irq_q)) & irr_q) == '0));

endmodule

// File: rtl/vic8_resolve.sv
// Module: vic8_resolve
// Priority resolver and in-service register. It picks the lowest-numbered
// unmasked request that no in-service bit outranks and forms the vector
// during an acknowledge. It also applies end of service, both automatic and
// specific. It assumes ack is a one-cycle pulse.
module vic8_resolve
    import vic8_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irr,
    input  logic [N_IN-1:0] imr,
    input  logic            ack,
    input  logic            aeoi,
    input  logic            init_clr,
    input  logic            eoi_valid,
    input  logic [2:0]      eoi_lvl,
    input  logic [DW-1:0]   vec_base,
    input  logic [DW-1:0]   casc_map,
    input  logic            role_master,
    output logic            int_out,
    output logic [DW-1:0]   vector,
    output logic            vec_drive,
    output logic [N_IN-1:0] isr,
    output logic [N_IN-1:0] ack_clr
);

    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N_IN - 1);

    logic [N_IN-1:0]  isr_q;
    logic [N_IN-1:0]  pend;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic [N_IN-1:0]  isr_set;
    logic [N_IN-1:0]  isr_clr;

    assign pend = irr & ~imr;

    // Fixed-priority search: a pending bit wins only if no in-service bit
    // sits at its own level or above.
    always_comb begin
        logic seen_isr;
        seen_isr = 1'b0;
        win_vld  = 1'b0;
        win_idx  = '0;
        for (int i = 0; i < N_IN; i++) begin
            seen_isr = seen_isr | isr_q[i];
            if (!win_vld && !seen_isr && pend[i]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    // Set and clear masks for the in-service register.
    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        ack_clr = '0;
        if (ack && win_vld) begin
            ack_clr[win_idx] = 1'b1;
            if (!aeoi) isr_set[win_idx] = 1'b1;
        end
        if (eoi_valid && (int'(eoi_lvl) < N_IN)) begin
            isr_clr[eoi_lvl[IDX_W-1:0]] = 1'b1;
        end
    end

    // In-service register update; an end of service wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) isr_q <= '0;
        else                    isr_q <= (isr_q | isr_set) & ~isr_clr;
    end

    // Vector and drive enable, valid while ack is high.
    always_comb begin
        vector    = '0;
        vec_drive = 1'b0;
        if (ack) begin
            vector    = vec_base + DW'(win_vld ? win_idx : SPUR_IDX);
            vec_drive = !(role_master && win_vld && casc_map[win_idx]);
        end
    end

    assign int_out = win_vld;
    assign isr     = isr_q;

    // R6
    int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    // R7
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !init_clr && !eoi_valid) |=> isr_q[$past(win_idx)]);

    // R8
    aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !eoi_valid && !init_clr) |=> (isr_q == $past(isr_q)));

    // R9
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !init_clr) |=> !isr_q[$past(eoi_lvl[IDX_W-1:0])]);

    // R11
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |-> (vector == vec_base + DW'(N_IN - 1)));

    // R12
    casc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && role_master && int_out && casc_map[win_idx]) |-> !vec_drive);

endmodule

// File: rtl/vic8_ctrl.sv
// Module: vic8_ctrl (top)
// Eight-input vectored interrupt controller. It connects the bus register
// file, the request register and the priority resolver. All inputs are
// assumed synchronous to clk; reset is synchronous and active low.
module vic8_ctrl
    import vic8_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] trig_level,
    input  logic            role_master,
    input  logic            ack,
    output logic            int_out,
    output logic [DW-1:0]   vector,
    output logic            vec_drive
);

    logic [N_IN-1:0] irr;
    logic [N_IN-1:0] isr;
    logic [N_IN-1:0] imr;
    logic [N_IN-1:0] ack_clr;
    logic            init_clr;
    logic            eoi_valid;
    logic [2:0]      eoi_lvl;
    logic [DW-1:0]   vec_base;
    logic [DW-1:0]   casc_map;
    logic            aeoi;
    logic            ltim;

    vic8_regs #(.N_IN(N_IN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irr       (irr),
        .isr       (isr),
        .init_clr  (init_clr),
        .eoi_valid (eoi_valid),
        .eoi_lvl   (eoi_lvl),
        .vec_base  (vec_base),
        .casc_map  (casc_map),
        .aeoi      (aeoi),
        .ltim      (ltim),
        .imr       (imr)
    );

    vic8_req #(.N_IN(N_IN)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .ltim       (ltim),
        .init_clr   (init_clr),
        .ack_clr    (ack_clr),
        .irr        (irr)
    );

    vic8_resolve #(.N_IN(N_IN)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .irr         (irr),
        .imr         (imr),
        .ack         (ack),
        .aeoi        (aeoi),
        .init_clr    (init_clr),
        .eoi_valid   (eoi_valid),
        .eoi_lvl     (eoi_lvl),
        .vec_base    (vec_base),
        .casc_map    (casc_map),
        .role_master (role_master),
        .int_out     (int_out),
        .vector      (vector),
        .vec_drive   (vec_drive),
        .isr         (isr),
        .ack_clr     (ack_clr)
    );

endmodule

// File: tb/sim_vic8_ctrl.sv
module sim_vic8_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_level = '0;
    logic       role_master = 1'b0;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vector;
    logic       vec_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .trig_level(trig_level), .role_master(role_master),
        .ack(ack), .int_out(int_out), .vector(vector), .vec_drive(vec_drive)
    );

    // Table rows: {mask[7:0], request pattern[7:0], expected int, expected vector offset[2:0]}.
    localparam int NVEC = 7;
    localparam logic [19:0] VEC_TBL [NVEC] = '{
        {8'h00, 8'h81, 1'b1, 3'd0},
        {8'h00, 8'h90, 1'b1, 3'd4},
        {8'h10, 8'h90, 1'b1, 3'd7},
        {8'h80, 8'h80, 1'b0, 3'd7},
        {8'hFE, 8'h03, 1'b1, 3'd0},
        {8'h0F, 8'h0F, 1'b0, 3'd7},
        {8'h00, 8'h40, 1'b1, 3'd6}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic drv);
        @(negedge clk);
        ack = 1'b1;
        #1 v = vector; drv = vec_drive;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_init(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, 8'h11);
        wr(1'b1, b);
        wr(1'b1, c);
        wr(1'b1, m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        logic       drv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 int", {7'd0, int_out}, 8'h00);
        rd(1'b1, d); chk("R1 mask", d, 8'hFF);
        rd(1'b0, d); chk("R1 irr", d, 8'h00);

        // Table walk: R5 R6 R7 R11
        for (int k = 0; k < NVEC; k++) begin
            set_irq(8'h00);
            do_init(8'h40, 8'h04, 8'h01);
            wr(1'b1, VEC_TBL[k][19:12]);
            set_irq(VEC_TBL[k][11:4]);
            chk($sformatf("R6 tbl%0d int", k), {7'd0, int_out}, {7'd0, VEC_TBL[k][3]});
            do_ack(v, drv);
            chk($sformatf("R7 tbl%0d vec", k), v, 8'h40 + {5'd0, VEC_TBL[k][2:0]});
        end

        // R2 initialization and mask access
        set_irq(8'h00);
        do_init(8'h20, 8'h04, 8'h01);
        rd(1'b1, d); chk("R3 mask after init", d, 8'hFF);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R2 mask load", d, 8'h00);

        // R5 masked request still latched
        wr(1'b1, 8'h02);
        set_irq(8'h02);
        chk("R5 masked int", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R5 irr latch", d, 8'h02);
        rd(1'b0, d); chk("R10 irr persists", d, 8'h02);
        set_irq(8'h00);
        do_init(8'h20, 8'h04, 8'h01);
        wr(1'b1, 8'h00);

        // R6 nesting and R9 specific end of service
        set_irq(8'h08);
        chk("R6 int 3", {7'd0, int_out}, 8'h01);
        do_ack(v, drv); chk("R7 vec 3", v, 8'h23);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 isr sel", d, 8'h08);
        set_irq(8'h28);
        chk("R6 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A);
        chk("R6 higher breaks", {7'd0, int_out}, 8'h01);
        do_ack(v, drv); chk("R7 vec 1", v, 8'h21);
        rd(1'b0, d); chk("R7 isr nest", d, 8'h0A);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R9 eoi 1 only", d, 8'h08);
        chk("R6 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        @(negedge clk);
        chk("R9 release 5", {7'd0, int_out}, 8'h01);
        do_ack(v, drv); chk("R7 vec 5", v, 8'h25);
        wr(1'b0, 8'h65);
        @(negedge clk);
        chk("R4 edge no relatch", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R7 irr cleared", d, 8'h00);

        // R4 level input
        trig_level = 8'h10;
        set_irq(8'h3A);
        chk("R4 level int", {7'd0, int_out}, 8'h01);
        do_ack(v, drv); chk("R4 level vec", v, 8'h24);
        wr(1'b0, 8'h64);
        @(negedge clk);
        chk("R4 level again", {7'd0, int_out}, 8'h01);
        set_irq(8'h2A);
        chk("R4 level gone", {7'd0, int_out}, 8'h00);

        // R11 request gone before acknowledge, then all masked
        set_irq(8'h3A);
        chk("R11 pre int", {7'd0, int_out}, 8'h01);
        set_irq(8'h2A);
        do_ack(v, drv); chk("R11 gone vec", v, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R11 isr none", d, 8'h00);
        wr(1'b1, 8'hFF);
        rd(1'b1, d); chk("R2 mask ff", d, 8'hFF);
        do_ack(v, drv); chk("R11 masked 7 vec", v, 8'h27);
        rd(1'b0, d); chk("R11 isr still none", d, 8'h00);
        trig_level = 8'h00;

        // R3 re-initialization with state present
        set_irq(8'h00);
        wr(1'b1, 8'h00);
        set_irq(8'h40);
        do_ack(v, drv); chk("R7 vec 6", v, 8'h26);
        rd(1'b0, d); chk("R7 isr 6", d, 8'h40);
        wr(1'b0, 8'h11);
        @(negedge clk);
        chk("R3 int low", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        set_irq(8'h42);
        rd(1'b0, d); chk("R3 sel irr", d, 8'h02);
        rd(1'b1, d); chk("R3 mask ff", d, 8'hFF);
        chk("R3 masked int", {7'd0, int_out}, 8'h00);

        // R8 automatic end of service
        set_irq(8'h00);
        do_init(8'h30, 8'h04, 8'h03);
        wr(1'b1, 8'h00);
        set_irq(8'h04);
        do_ack(v, drv); chk("R8 vec", v, 8'h32);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 isr empty", d, 8'h00);
        chk("R8 int", {7'd0, int_out}, 8'h00);

        // R12 cascade head behaviour
        role_master = 1'b1;
        set_irq(8'h00);
        do_init(8'h50, 8'h04, 8'h01);
        wr(1'b1, 8'h00);
        set_irq(8'h04);
        do_ack(v, drv);
        chk("R12 cascade off bus", {7'd0, drv}, 8'h00);
        wr(1'b0, 8'h62);
        set_irq(8'h44);
        do_ack(v, drv);
        chk("R12 plain input drives", {7'd0, drv}, 8'h01);
        chk("R12 vec 6", v, 8'h56);
        wr(1'b0, 8'h66);
        role_master = 1'b0;
        set_irq(8'h00);
        set_irq(8'h04);
        do_ack(v, drv);
        chk("R12 slave drives", {7'd0, drv}, 8'h01);
        chk("R12 slave vec", v, 8'h52);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule